// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block deserialises a stereo PCM stream carried on a bit clock, a frame clock and a single data line. It returns one left and one right sample per frame. Both are 24-bit two's-complement words and come with a one-cycle valid strobe. A 3-bit format input picks the framing. Three right-justified framings carry 16, 20 or 24 data bits, one left-justified framing carries 24 bits, and the fifth framing is I2S. Two inputs invert the sense of the frame clock and the bit clock.

All state is clocked by the bit clock, after the polarity control has been applied. No preset frame length is needed. Right-justified words are taken from the tail of each half-frame, and left-justified and I2S words from its head. Any legal bit-clock ratio therefore works without configuration. A left/right pair is released once the right word is complete. The pair goes out only if both halves were seen in full since reset.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted (rstN low), leftOut and rightOut are zero and sampleValid is low.
- R2: Format code 3'b010 (left-justified) takes the first 24 bits after a frame-clock edge, MSB first, as the sample. A 16-bit word followed by eight zeros decodes as that word shifted left by 8, and a 20-bit word followed by four zeros decodes the same way with a shift of 4. Bit clocks of 48 to 64 per frame are accepted.
- R3: Format code 3'b011 (I2S) places the sample MSB one bit-clock after the frame-clock edge, and frame clock low marks the left channel. At 32 bit clocks per frame the 16 received bits fill bits 23..8, and bits 7..0 are zero. At 48 to 64 bit clocks per frame, 24 bits are taken.
- R4: Format code 3'b000 takes the last 16 bits of each half-frame as the sample and sign-extends them to 24 bits. Bits ahead of them are ignored. 32 to 64 bit clocks per frame are accepted.
- R5: Format code 3'b001 takes the last 20 bits of each half-frame and sign-extends them to 24 bits. Earlier bits are ignored. 40 to 64 bit clocks per frame are accepted.
- R6: Format code 3'b100 takes the last 24 bits of each half-frame. Earlier bits are ignored. 48 to 64 bit clocks per frame are accepted.
- R7: In every format except I2S, frame clock high marks the left channel. Each frame gives exactly one sampleValid pulse, one bit-clock cycle wide. The pulse appears on the rising edge where the first bit of the next frame is sampled. leftOut and rightOut change only on that edge.
- R8: When lrInvert is 1 the frame clock is inverted before use. The reset-time default is 0, meaning not inverted.
- R9: When bckInvert is 1, data and frame clock are captured on the falling edge of bitClk instead of the rising edge.
- R10: Format codes 3'b101, 3'b110 and 3'b111 never produce a sampleValid pulse.
- R11: After reset, no pair is released until one left half and then one right half have each been received in full between frame-clock edges. A partial half present at reset release is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lrClk | input | 1 | Frame (channel select) clock |
| serData | input | 1 | Serial audio data, MSB first |
| fmtSel | input | 3 | Framing select code |
| lrInvert | input | 1 | Invert frame-clock sense when 1 |
| bckInvert | input | 1 | Capture on falling bitClk edge when 1 |
| leftOut | output | 24 | Left sample, two's complement |
| rightOut | output | 24 | Right sample, two's complement |
| sampleValid | output | 1 | One-cycle strobe: new pair on outputs |

## Verification
The bench sends negative words to the right-justified framings. A receiver that zero-extends instead of sign-extending returns a positive value there. It also sends half-frames that are much longer than the sample, with junk bits in front. A receiver that counts from the frame edge picks up those junk bits. I2S is run at 32 bit clocks per frame, where the previous word's LSB shares the edge with the channel change. A receiver that ignores the one-bit delay, or that leaves stale low bits, returns shifted or polluted words. Further cases cover both polarity inputs, the unused codes, and a partial half at reset release. In these cases a wrong design emits swapped channels, emits pulses for unused codes, or emits a pair built from a truncated half.

// File: rtl/audio_serial_rx_pkg.sv
package audio_serial_rx_pkg;

  typedef enum logic [2:0] {
    FMT_RJ16 = 3'b000,
    FMT_RJ20 = 3'b001,
    FMT_LJ24 = 3'b010,
    FMT_I2S  = 3'b011,
    FMT_RJ24 = 3'b100
  } fmt_e;

  // strobes from framing control to datapath, one bit-clock each
  typedef struct packed {
    logic halfStart;  // this edge carries bit 0 of a new half-frame
    logic capEn;      // head capture still filling
    logic latchLeft;  // a complete left half just ended
    logic emitFrame;  // a complete right half just ended, pair ready
  } strobes_t;

endpackage

// File: rtl/audio_serial_rx_ctrl.sv
module audio_serial_rx_ctrl
  import audio_serial_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lrIn,
  input  logic             lrInvert,
  input  logic [2:0]       fmtSel,
  output strobes_t         strobes,
  output logic [CNT_W-1:0] capIdx
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic lrNow, lrDly, frmNow, frmPrev;
  logic isI2s, fmtLegal, boundary, endingLeft;
  logic [1:0] armCnt;
  logic halfSeen, leftReady;
  logic [CNT_W-1:0] bitCnt;

  assign lrNow    = lrIn ^ lrInvert;
  assign isI2s    = (fmtSel == FMT_I2S);
  assign fmtLegal = (fmtSel <= 3'd4);
  // I2S framing lags the frame clock by one bit
  assign frmNow   = isI2s ? lrDly : lrNow;
  assign boundary = (armCnt == 2'd2) && (frmNow != frmPrev);
  // channel of the half that is finishing
  assign endingLeft = isI2s ? ~frmPrev : frmPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrDly     <= 1'b0;
      frmPrev   <= 1'b0;
      armCnt    <= 2'd0;
      halfSeen  <= 1'b0;
      leftReady <= 1'b0;
      bitCnt    <= '0;
    end else begin
      lrDly   <= lrNow;
      frmPrev <= frmNow;
      if (armCnt != 2'd2) armCnt <= armCnt + 2'd1;
      if (boundary) begin
        bitCnt   <= CNT_ONE;
        halfSeen <= 1'b1;
        if (halfSeen) leftReady <= endingLeft;
        else          leftReady <= 1'b0;
      end else if (bitCnt < CNT_MAX) begin
        bitCnt <= bitCnt + CNT_ONE;
      end
    end
  end

  always_comb begin
    strobes.halfStart = boundary;
    strobes.capEn     = !boundary && (bitCnt < CNT_MAX);
    strobes.latchLeft = boundary && halfSeen && endingLeft;
    strobes.emitFrame = boundary && halfSeen && !endingLeft && leftReady && fmtLegal;
    capIdx            = bitCnt;
  end

endmodule

// File: rtl/audio_serial_rx_dpath.sv
module audio_serial_rx_dpath
  import audio_serial_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16,
  parameter int MID_W    = 20,
  parameter int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sdIn,
  input  logic [2:0]          fmtSel,
  input  strobes_t            strobes,
  input  logic [CNT_W-1:0]    capIdx,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                sampleValid
);

  logic [SAMPLE_W-1:0] shiftReg, capReg, leftHold, rjWord, doneWord, headBit;
  logic useHead;

  assign useHead = (fmtSel == FMT_LJ24) || (fmtSel == FMT_I2S);
  assign headBit = {sdIn, {(SAMPLE_W-1){1'b0}}};

  // tail of half-frame: last N bits, sign-extended
  always_comb begin
    case (fmtSel)
      FMT_RJ16: rjWord = {{(SAMPLE_W-NARROW_W){shiftReg[NARROW_W-1]}}, shiftReg[NARROW_W-1:0]};
      FMT_RJ20: rjWord = {{(SAMPLE_W-MID_W){shiftReg[MID_W-1]}}, shiftReg[MID_W-1:0]};
      default:  rjWord = shiftReg;
    endcase
    doneWord = useHead ? capReg : rjWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      capReg      <= '0;
      leftHold    <= '0;
      leftOut     <= '0;
      rightOut    <= '0;
      sampleValid <= 1'b0;
    end else begin
      shiftReg <= {shiftReg[SAMPLE_W-2:0], sdIn};
      if (strobes.halfStart)  capReg <= headBit;
      else if (strobes.capEn) capReg <= capReg | (headBit >> capIdx);
      if (strobes.latchLeft) leftHold <= doneWord;
      sampleValid <= strobes.emitFrame;
      if (strobes.emitFrame) begin
        leftOut  <= leftHold;
        rightOut <= doneWord;
      end
    end
  end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audio_serial_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16,
  parameter int MID_W    = 20
) (
  input  logic                bitClk,
  input  logic                rstN,
  input  logic                lrClk,
  input  logic                serData,
  input  logic [2:0]          fmtSel,
  input  logic                lrInvert,
  input  logic                bckInvert,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                sampleValid
);

  localparam int CNT_W = $clog2(SAMPLE_W + 1);

  logic sclk;
  strobes_t strobes;
  logic [CNT_W-1:0] capIdx;

  assign sclk = bitClk ^ bckInvert;

  audio_serial_rx_ctrl #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(sclk), .rstN(rstN), .lrIn(lrClk), .lrInvert(lrInvert),
    .fmtSel(fmtSel), .strobes(strobes), .capIdx(capIdx)
  );

  audio_serial_rx_dpath #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W), .MID_W(MID_W),
                          .CNT_W(CNT_W)) dpath_i (
    .clk(sclk), .rstN(rstN), .sdIn(serData), .fmtSel(fmtSel),
    .strobes(strobes), .capIdx(capIdx), .leftOut(leftOut),
    .rightOut(rightOut), .sampleValid(sampleValid)
  );

endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk #(
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16,
  parameter int MID_W    = 20
) (
  input logic                clk,
  input logic                rstN,
  input logic [2:0]          fmtSel,
  input logic [SAMPLE_W-1:0] leftOut,
  input logic [SAMPLE_W-1:0] rightOut,
  input logic                sampleValid
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> (!sampleValid && leftOut == '0 && rightOut == '0));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R7
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(leftOut) && $stable(rightOut)));

  // R10
  unused_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fmtSel > 3'd4) |=> !sampleValid);

  // R4
  sign_ext16_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && fmtSel == 3'b000 && $stable(fmtSel)) |->
      ((leftOut[SAMPLE_W-1:NARROW_W-1] == '0 || leftOut[SAMPLE_W-1:NARROW_W-1] == '1) &&
       (rightOut[SAMPLE_W-1:NARROW_W-1] == '0 || rightOut[SAMPLE_W-1:NARROW_W-1] == '1)));

  // R5
  sign_ext20_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && fmtSel == 3'b001 && $stable(fmtSel)) |->
      ((leftOut[SAMPLE_W-1:MID_W-1] == '0 || leftOut[SAMPLE_W-1:MID_W-1] == '1) &&
       (rightOut[SAMPLE_W-1:MID_W-1] == '0 || rightOut[SAMPLE_W-1:MID_W-1] == '1)));

endmodule

bind audio_serial_rx audio_serial_rx_chk #(
  .SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W), .MID_W(MID_W)
) chk_i (
  .clk(sclk), .rstN(rstN), .fmtSel(fmtSel), .leftOut(leftOut),
  .rightOut(rightOut), .sampleValid(sampleValid)
);

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb_top;

  logic bitClk = 1'b0;
  logic rstN = 1'b1;
  logic lrClk = 1'b0;
  logic serData = 1'b0;
  logic [2:0] fmtSel = 3'b010;
  logic lrInvert = 1'b0;
  logic bckInvert = 1'b0;
  logic [23:0] leftOut, rightOut;
  logic sampleValid;
  logic effClk;

  int checks = 0;
  int failures = 0;
  int gotCnt = 0;
  logic [23:0] gotL [4];
  logic [23:0] gotR [4];
  logic pend = 1'b0;

  always #2 bitClk = ~bitClk;
  assign effClk = bitClk ^ bckInvert;

  audio_serial_rx dut_i (
    .bitClk(bitClk), .rstN(rstN), .lrClk(lrClk), .serData(serData),
    .fmtSel(fmtSel), .lrInvert(lrInvert), .bckInvert(bckInvert),
    .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
  );

  // collect every released pair, half a cycle after the capture edge
  always @(negedge effClk) begin
    if (rstN && sampleValid) begin
      if (gotCnt < 4) begin
        gotL[gotCnt] = leftOut;
        gotR[gotCnt] = rightOut;
      end
      gotCnt = gotCnt + 1;
    end
  end

  // {fmt, bits per half, lrInvert, bckInvert, left word, right word}
  localparam int NVEC = 11;
  localparam logic [59:0] VEC [NVEC] = '{
    {3'b010, 7'd24, 1'b0, 1'b0, 24'h7A5C31, 24'h85A3CE},
    {3'b010, 7'd32, 1'b1, 1'b0, 24'h123400, 24'hFEDCB0},
    {3'b011, 7'd16, 1'b0, 1'b0, 24'h4B1E77, 24'hC0FFEE},
    {3'b011, 7'd32, 1'b0, 1'b1, 24'h800001, 24'h7FFFFE},
    {3'b011, 7'd24, 1'b1, 1'b0, 24'h13579B, 24'hECA864},
    {3'b000, 7'd16, 1'b0, 1'b0, 24'h008001, 24'h007FFF},
    {3'b000, 7'd32, 1'b1, 1'b0, 24'hAA1234, 24'h55F00F},
    {3'b001, 7'd20, 1'b0, 1'b0, 24'h0FFFFF, 24'h07ABCD},
    {3'b001, 7'd32, 1'b1, 1'b1, 24'h380000, 24'h912345},
    {3'b100, 7'd24, 1'b0, 1'b0, 24'hA1B2C3, 24'h1D2E3F},
    {3'b100, 7'd32, 1'b0, 1'b1, 24'h000000, 24'hFFFFFF}
  };

  function automatic logic [23:0] expWord(input logic [2:0] f, input int n, input logic [23:0] w);
    int k;
    case (f)
      3'b000:  return {{8{w[15]}}, w[15:0]};
      3'b001:  return {{4{w[19]}}, w[19:0]};
      3'b100:  return w;
      default: begin
        k = (n < 24) ? n : 24;
        return w & ~(24'hFFFFFF >> k);
      end
    endcase
  endfunction

  function automatic logic bitAt(input logic [2:0] f, input int n, input logic [23:0] w, input int i);
    int wd;
    wd = (f == 3'b000) ? 16 : (f == 3'b001) ? 20 : 24;
    if (f == 3'b010 || f == 3'b011) return (i < 24) ? w[23-i] : 1'b0;
    if (i >= n - wd) return w[wd-1-(i-(n-wd))];
    return i[0];  // junk ahead of a right-justified word
  endfunction

  function automatic string tagOf(input logic [2:0] f, input logic li, input logic bi);
    string s;
    case (f)
      3'b010:  s = "R2";
      3'b011:  s = "R3";
      3'b000:  s = "R4";
      3'b001:  s = "R5";
      default: s = "R6";
    endcase
    if (li) s = {s, " R8"};
    if (bi) s = {s, " R9"};
    return s;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic driveBit(input logic lvl, input logic nom);
    @(negedge effClk);
    lrClk = lvl ^ lrInvert;
    serData = (fmtSel == 3'b011) ? pend : nom;
    pend = nom;
  endtask

  function automatic logic leftLvl();
    return (fmtSel == 3'b011) ? 1'b0 : 1'b1;
  endfunction

  task automatic sendHalf(input logic isLeft, input int n, input logic [23:0] w);
    for (int i = 0; i < n; i++)
      driveBit(isLeft ? leftLvl() : ~leftLvl(), bitAt(fmtSel, n, w, i));
  endtask

  task automatic idle(input logic lvl, input int cnt);
    for (int i = 0; i < cnt; i++) driveBit(lvl, 1'b0);
  endtask

  task automatic applyReset(input logic li, input logic bi, input logic [2:0] f);
    rstN = 1'b0;
    lrInvert = li;
    bckInvert = bi;
    fmtSel = f;
    pend = 1'b0;
    serData = 1'b0;
    lrClk = ~leftLvl() ^ li;
    #9;
    // R1: cleared while reset is held
    check(leftOut == 24'h0 && rightOut == 24'h0 && !sampleValid, "R1 reset",
          {7'd0, sampleValid, leftOut}, 32'h0);
    gotCnt = 0;
    @(negedge effClk);
    rstN = 1'b1;
  endtask

  initial begin
    #1 rstN = 1'b0;
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] f;
      int n;
      logic li, bi;
      logic [23:0] wl, wr;
      string tag;
      {f, n[6:0], li, bi, wl, wr} = {VEC[v][59:57], VEC[v][56:50], VEC[v][49], VEC[v][48],
                                     VEC[v][47:24], VEC[v][23:0]};
      n = int'(VEC[v][56:50]);
      tag = tagOf(f, li, bi);
      applyReset(li, bi, f);
      idle(~leftLvl(), 4);
      sendHalf(1'b1, n, wl);
      sendHalf(1'b0, n, wr);
      sendHalf(1'b1, n, wr);
      sendHalf(1'b0, n, wl);
      sendHalf(1'b1, n, 24'h0);   // terminator half
      idle(leftLvl(), 4);
      // R7: one pulse per frame
      check(gotCnt == 2, {tag, " R7 count"}, gotCnt, 2);
      check(gotL[0] == expWord(f, n, wl), {tag, " left0"}, {8'd0, gotL[0]}, {8'd0, expWord(f, n, wl)});
      check(gotR[0] == expWord(f, n, wr), {tag, " right0"}, {8'd0, gotR[0]}, {8'd0, expWord(f, n, wr)});
      check(gotL[1] == expWord(f, n, wr), {tag, " left1"}, {8'd0, gotL[1]}, {8'd0, expWord(f, n, wr)});
      check(gotR[1] == expWord(f, n, wl), {tag, " right1"}, {8'd0, gotR[1]}, {8'd0, expWord(f, n, wl)});
    end

    // R10: unused codes release nothing
    for (int c = 5; c < 8; c++) begin
      applyReset(1'b0, 1'b0, 3'(c));
      idle(1'b0, 4);
      sendHalf(1'b1, 24, 24'h5A5A5A);
      sendHalf(1'b0, 24, 24'hA5A5A5);
      sendHalf(1'b1, 24, 24'h111111);
      idle(1'b1, 4);
      check(gotCnt == 0, "R10 unused code pulses", gotCnt, 0);
      check(leftOut == 24'h0 && rightOut == 24'h0, "R10 outputs untouched", {8'd0, leftOut}, 0);
    end

    // R11: partial left half at reset release is discarded
    applyReset(1'b0, 1'b0, 3'b100);
    idle(1'b1, 10);                 // tail of a left half
    sendHalf(1'b0, 24, 24'h0F0F0F);  // right half after a partial left
    sendHalf(1'b1, 24, 24'h123456);
    sendHalf(1'b0, 24, 24'h654321);
    sendHalf(1'b1, 24, 24'h0);
    idle(1'b1, 4);
    check(gotCnt == 1, "R11 pulse count", gotCnt, 1);
    check(gotL[0] == 24'h123456, "R11 left", {8'd0, gotL[0]}, 32'h123456);
    check(gotR[0] == 24'h654321, "R11 right", {8'd0, gotR[0]}, 32'h654321);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge bitClk);
    failures = failures + 1;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule